// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block decides when a DRAM refresh cycle is due and asks a separate memory controller to perform it. A free-running prescaler feeds a reloading 8-bit down-counter. Each time the counter expires, a refresh becomes pending. The pending refresh is offered on a request/acknowledge pair, but only while no word transfer is in progress. The memory controller then runs the CAS-before-RAS cycle and acknowledges it.

Software controls the block through one 24-bit register. The register holds the divider reload value, the prescaler choice, two enables and a one-shot bit. The enables are a normal run enable and a separate enable that applies while the processor is in debug mode. The one-shot bit asks for a single refresh regardless of both enables. Hardware clears it once that refresh has been accepted. A synchronous soft reset clears the timing fields and restarts the counters.

Top module: `drt_refresh_timer`

## Requirements
- R1: After the asynchronous reset, the register reads 0 and `ref_req` is low.
- R2: Register bits 8 to 17 and bit 21 always read 0, whatever value is written.
- R3: Register bits 7:0 hold a reload value P. The down-counter expires once every P+1 prescaler ticks, so 0x00 gives a ratio of 1 and 0xFF gives a ratio of 256.
- R4: Register bits 19:18 select the prescaler. The codes are 00 for divide by 64, 01 for divide by 8, and 10 for one tick per clock. Code 11 behaves like 10. With requests acknowledged at once, successive requests are N*(P+1) clocks apart, where N is the prescaler ratio.
- R5: Outside debug mode, periodic requests occur only while bit 23 (run enable) is 1. Bit 22 alone gives none.
- R6: While `debug_mode` is 1, periodic requests occur only while bit 22 (debug enable) is 1, at the timer rate. Bit 23 alone gives none.
- R7: Writing 1 to bit 20 (one-shot) raises `ref_req` even with both enables at 0. `ref_req` stays low while `xfer_busy` is 1 and rises once `xfer_busy` falls.
- R8: An accepted request (`ref_req` and `ref_ack` both 1) clears bit 20, and the one-shot produces no further request.
- R9: A pending periodic refresh holds `ref_req` until it is acknowledged. Further expiries that arrive meanwhile merge into it, so one acknowledge clears them all. A pending refresh is withheld while `xfer_busy` is 1.
- R10: `sw_rst` clears the reload value, the prescaler select, the one-shot bit, the pending flag and both counters. It leaves bits 22 and 23 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous soft reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data |
| xfer_busy | input | 1 | A word transfer is in progress |
| debug_mode | input | 1 | Processor is in debug mode |
| ref_req | output | 1 | Refresh requested |
| ref_ack | input | 1 | Memory controller accepts the request |

## Verification
The assertions take `ref_ack` to matter only in a cycle where `ref_req` is high. They also assume that `sw_rst` and register writes occur in separate cycles. The hold and one-shot clearing properties are therefore guarded by those inputs being idle. The stimulus changes inputs just after a rising edge and never asserts a write and a soft reset together. It holds `ref_ack` high throughout the period measurements, so each expiry is accepted in the cycle it is offered. Outside those measurements, `ref_ack` is pulsed only once a request has been seen.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int REG_W       = 24;
  localparam int DIV_W       = 8;
  localparam int PRE_SEL_LSB = 18;
  localparam int OS_BIT      = 20;
  localparam int DBG_EN_BIT  = 22;
  localparam int RUN_EN_BIT  = 23;
  localparam logic [REG_W-1:0] RSV_MASK = 24'h23FF00;

  typedef enum logic [1:0] {
    PRE_SLOW = 2'b00,
    PRE_MID  = 2'b01,
    PRE_BYP  = 2'b10,
    PRE_RSV  = 2'b11
  } pre_sel_e;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler
  import drt_pkg::*;
#(
  parameter int SLOW_DIV = 64,
  parameter int MID_DIV  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  pre_sel_e sel,
  output logic     tick
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    unique case (sel)
      PRE_SLOW: lim = CW'(SLOW_DIV - 1);
      PRE_MID:  lim = CW'(MID_DIV - 1);
      default:  lim = '0;
    endcase
  end

  assign tick = (cnt_q >= lim);

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/drt_divider.sv
module drt_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] preset,
  output logic         tc
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tc = tick && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tc)   cnt_d = preset;
    else if (tick) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr) |=> (cnt_q == $past(preset)));
endmodule

// File: rtl/drt_req_arb.sv
module drt_req_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tc,
  input  logic per_en,
  input  logic os_pend,
  input  logic xfer_busy,
  input  logic ref_ack,
  output logic ref_req,
  output logic grant
);
  logic pend_q, pend_d;

  assign ref_req = (pend_q || os_pend) && !xfer_busy;
  assign grant   = ref_req && ref_ack;

  always_comb begin
    if (clr)                pend_d = 1'b0;
    else if (tc && per_en)  pend_d = 1'b1;
    else                    pend_d = pend_q && !grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant && !clr) |=> pend_q);
endmodule

// File: rtl/drt_refresh_timer.sv
module drt_refresh_timer
  import drt_pkg::*;
#(
  parameter int SLOW_DIV = 64,
  parameter int MID_DIV  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             xfer_busy,
  input  logic             debug_mode,
  output logic             ref_req,
  input  logic             ref_ack
);
  logic [DIV_W-1:0] preset_q, preset_d;
  pre_sel_e         presel_q, presel_d;
  logic             os_q, os_d;
  logic             dbg_en_q, dbg_en_d;
  logic             run_en_q, run_en_d;
  logic             tick, tc, grant, per_en;

  always_comb begin
    preset_d = preset_q;
    presel_d = presel_q;
    dbg_en_d = dbg_en_q;
    run_en_d = run_en_q;
    os_d     = os_q && !grant;
    if (sw_rst) begin
      preset_d = '0;
      presel_d = PRE_SLOW;
      os_d     = 1'b0;
    end else if (reg_wr_en) begin
      preset_d = reg_wdata[DIV_W-1:0];
      presel_d = pre_sel_e'(reg_wdata[PRE_SEL_LSB +: 2]);
      os_d     = reg_wdata[OS_BIT];
      dbg_en_d = reg_wdata[DBG_EN_BIT];
      run_en_d = reg_wdata[RUN_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      presel_q <= PRE_SLOW;
      os_q     <= 1'b0;
      dbg_en_q <= 1'b0;
      run_en_q <= 1'b0;
    end else begin
      preset_q <= preset_d;
      presel_q <= presel_d;
      os_q     <= os_d;
      dbg_en_q <= dbg_en_d;
      run_en_q <= run_en_d;
    end
  end

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[DIV_W-1:0]             = preset_q;
    reg_rdata[PRE_SEL_LSB +: 2]      = presel_q;
    reg_rdata[OS_BIT]                = os_q;
    reg_rdata[DBG_EN_BIT]            = dbg_en_q;
    reg_rdata[RUN_EN_BIT]            = run_en_q;
  end

  assign per_en = debug_mode ? dbg_en_q : run_en_q;

  drt_prescaler #(.SLOW_DIV(SLOW_DIV), .MID_DIV(MID_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .sel(presel_q), .tick(tick)
  );

  drt_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .tick(tick),
    .preset(preset_q), .tc(tc)
  );

  drt_req_arb u_arb (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .tc(tc), .per_en(per_en),
    .os_pend(os_q), .xfer_busy(xfer_busy), .ref_ack(ref_ack),
    .ref_req(ref_req), .grant(grant)
  );

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSV_MASK) == '0);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> !ref_req);

  // R8
  os_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack && !reg_wr_en && !sw_rst) |=> !reg_rdata[OS_BIT]);

  // R10
  swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (reg_rdata[PRE_SEL_LSB +: 2] == 2'b00 && reg_rdata[DIV_W-1:0] == '0
                && !reg_rdata[OS_BIT]
                && reg_rdata[DBG_EN_BIT] == $past(reg_rdata[DBG_EN_BIT])
                && reg_rdata[RUN_EN_BIT] == $past(reg_rdata[RUN_EN_BIT])));
endmodule

// File: tb/drt_refresh_timer_test.sv
module drt_refresh_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        xfer_busy = 1'b0;
  logic        debug_mode = 1'b0;
  logic        ref_req;
  logic        ref_ack = 1'b1;

  localparam logic [23:0] RUN = 24'h800000;
  localparam logic [23:0] DBG = 24'h400000;
  localparam logic [23:0] OS  = 24'h100000;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit last_ok = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  drt_refresh_timer uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_busy(xfer_busy),
    .debug_mode(debug_mode), .ref_req(ref_req), .ref_ack(ref_ack)
  );

  task automatic check(string r, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: scoreboard of request spacing
  always @(negedge clk) begin
    cyc++;
    if (rst_n && ref_req) begin
      if (exp_q.size() > 0 && last_ok) begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, cyc - last_cyc, e);
      end
      last_cyc = cyc;
      last_ok = 1;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [23:0] d);
    step(); reg_wr_en = 1'b1; reg_wdata = d;
    step(); reg_wr_en = 1'b0;
  endtask

  task automatic soft_reset();
    step(); sw_rst = 1'b1;
    step(); sw_rst = 1'b0;
  endtask

  task automatic count_reqs(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ref_req) hits++;
    end
  endtask

  // driver: configure, then push expected gaps
  task automatic run_period(logic [23:0] cfg, int gap, string tag);
    ref_ack = 1'b1;
    soft_reset();
    wr(cfg);
    do @(negedge clk); while (!ref_req);
    step();
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(gap);
      tag_q.push_back(tag);
    end
    while (exp_q.size() > 0) @(negedge clk);
    wr(24'h0);
    repeat (3) step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int hits;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reg", reg_rdata, 0);
    check("R1 req", ref_req, 0);

    wr(24'hFFFFFF);
    @(negedge clk);
    check("R2 reserved", reg_rdata & 24'h23FF00, 0);
    wr(24'h0);
    repeat (3) step();

    run_period(RUN | 24'h080003, 4,   "R4 bypass");
    run_period(RUN | 24'h040002, 24,  "R4 div8");
    run_period(RUN | 24'h000001, 128, "R4 div64");
    run_period(RUN | 24'h0C0001, 2,   "R4 code11");
    run_period(RUN | 24'h0800FF, 256, "R3 max");
    run_period(RUN | 24'h080000 | 24'h07, 8, "R3 preset7");

    // R5: debug enable alone does nothing outside debug mode
    soft_reset();
    wr(DBG | 24'h080002);
    count_reqs(200, hits);
    check("R5 no run enable", hits, 0);
    wr(24'h0);

    // R6: run enable alone does nothing in debug mode
    debug_mode = 1'b1;
    soft_reset();
    wr(RUN | 24'h080002);
    count_reqs(200, hits);
    check("R6 debug blocked", hits, 0);
    wr(24'h0);
    run_period(DBG | 24'h080004, 5, "R6 debug rate");
    debug_mode = 1'b0;

    // R7/R8: one-shot with enables off, held by busy
    soft_reset();
    ref_ack = 1'b0;
    xfer_busy = 1'b1;
    wr(OS);
    count_reqs(20, hits);
    check("R7 busy hold", hits, 0);
    step(); xfer_busy = 1'b0;
    @(negedge clk);
    check("R7 oneshot req", ref_req, 1);
    step(); ref_ack = 1'b1;
    step(); ref_ack = 1'b0;
    @(negedge clk);
    check("R8 req cleared", ref_req, 0);
    check("R8 bit cleared", reg_rdata[20], 0);
    count_reqs(30, hits);
    check("R8 single", hits, 0);

    // R9: merging of expiries
    soft_reset();
    wr(RUN | 24'h080003);
    repeat (40) step();
    @(negedge clk);
    check("R9 held", ref_req, 1);
    wr(24'h0);
    step(); ref_ack = 1'b1;
    step(); ref_ack = 1'b0;
    @(negedge clk);
    check("R9 merged", ref_req, 0);

    // R9: deferral while busy
    ref_ack = 1'b1;
    soft_reset();
    xfer_busy = 1'b1;
    wr(RUN | 24'h080003);
    count_reqs(30, hits);
    check("R9 busy defer", hits, 0);
    step(); xfer_busy = 1'b0;
    @(negedge clk);
    check("R9 after busy", ref_req, 1);
    wr(24'h0);
    repeat (3) step();

    // R10: soft reset keeps enables only
    ref_ack = 1'b0;
    wr(RUN | DBG | 24'h040055);
    soft_reset();
    @(negedge clk);
    check("R10 fields", reg_rdata, 24'hC00000);
    wr(24'h0);
    count_reqs(5, hits);
    check("R10 no pending", hits, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule